// File: doc/BRIEF.md
# Double-Buffered DAC Code Register

This block sits between a byte-wide CPU bus and a 10-bit digital-to-analog converter. It holds the converter code in a shadow register that the bus can neither read nor write. Software changes that code by writing a low byte and a high byte. A low byte write only updates a pending holding value. A high byte write commits the holding value into a staged pair. The shadow register then takes the new code, so the converter never sees a half-written code.

A control register sets two things. The alignment mode chooses how the ten code bits are split between the two bytes. The left-adjusted layout lets 8-bit users write the high byte alone. The trigger mode chooses when the shadow register loads. In direct mode it loads at the high byte write. In triggered mode it loads on each rising edge of one of eight trigger inputs, picked by a select field. Both byte registers and the control register can be read back through a combinational read port.

Top module: `dacbuf_top`

## Requirements
- R1: After reset the converter code, both byte readbacks and the control readback are zero.
- R2: With alignment 0 (right), low byte bits 7:0 map to code bits 7:0, high byte bits 1:0 map to code bits 9:8, and high byte bits 7:2 are ignored and read back as zero.
- R3: A write to the low byte (address 0) never changes the converter code by itself.
- R4: With the trigger mode bit clear, a write to the high byte (address 1) places the combined pending code on the converter output at the clock edge that accepts the write.
- R5: With the trigger mode bit set, a high byte write leaves the output unchanged. Every selected trigger event loads the most recently committed code.
- R6: A trigger event is a 0-to-1 change of the trigger input numbered by the select field (control bits 4:2), seen between two clock edges. Other inputs, held levels and falling edges cause no load.
- R7: With alignment 1 (left), the high byte maps to code bits 9:2 and low byte bits 7:6 map to code bits 1:0. Writing only the high byte gives 8-bit operation.
- R8: When a high byte write and a selected trigger event occur in the same cycle, the output takes the code committed by that write.
- R9: Changing the alignment bit does not alter the converter code. Readback of the byte registers follows the new alignment.
- R10: With the trigger mode bit clear, trigger inputs have no effect on the output.
- R11: The control register at address 2 holds the trigger mode in bit 0, alignment in bit 1 and the select field in bits 4:2. Bits 7:5 read as zero. Address 3 reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe |
| wrAddr | input | 2 | Write address: 0 low, 1 high, 2 control, 3 none |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read address, same map as writes |
| rdData | output | 8 | Combinational read data |
| trigIn | input | 8 | Trigger event inputs |
| dacCode | output | 10 | Shadow register contents driving the converter |

## Verification
The assertions check on every cycle that:
- a low byte write alone leaves the shadow register unchanged;
- in direct mode a high byte write lands the staged pair on the output on the next cycle;
- in triggered mode the output holds still unless the selected edge fires;
- a held trigger level cannot fire twice.

Only the bench scenarios show the following:
- the bit mapping of both alignments;
- readback reinterpretation after an alignment change;
- rejection of unselected inputs;
- priority of a fresh commit over the older staged pair in the same cycle;
- reset values.

// File: rtl/dacbuf_pkg.sv
package dacbuf_pkg;

  typedef enum logic [1:0] {
    REG_LOW  = 2'd0,
    REG_HIGH = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } regSel_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic wrLow;       // write low byte into holding value
    logic wrHigh;      // write high byte and commit staged pair
    logic loadShadow;  // load converter shadow register
    logic fromFresh;   // shadow takes the pair committed this cycle
    logic leftAdj;     // current alignment mode
  } dpStrobe_t;

endpackage

// File: rtl/dacbuf_ctrl.sv
module dacbuf_ctrl
  import dacbuf_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int NUM_TRIG = 8,
  localparam int SEL_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1,
  localparam int CTRL_W  = 2 + SEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [CTRL_W-1:0] ctrlData,
  input  logic [NUM_TRIG-1:0] trigIn,
  output dpStrobe_t         strb,
  output logic [BYTE_W-1:0] ctrlRead,
  output logic              autoTrig,
  output logic              trigEvent
);

  localparam int AUTO_BIT = 0;
  localparam int LEFT_BIT = 1;
  localparam int SEL_LSB  = 2;

  logic              leftAdjQ;
  logic [SEL_W-1:0]  trigSelQ;
  logic [NUM_TRIG-1:0] trigPrevQ;
  logic [NUM_TRIG-1:0] trigRise;
  logic              wrLow, wrHigh, wrCtrl;

  always_comb begin
    wrLow  = wrEn && (wrAddr == REG_LOW);
    wrHigh = wrEn && (wrAddr == REG_HIGH);
    wrCtrl = wrEn && (wrAddr == REG_CTRL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      autoTrig <= 1'b0;
      leftAdjQ <= 1'b0;
      trigSelQ <= '0;
    end else if (wrCtrl) begin
      autoTrig <= ctrlData[AUTO_BIT];
      leftAdjQ <= ctrlData[LEFT_BIT];
      trigSelQ <= ctrlData[SEL_LSB +: SEL_W];
    end
  end

  // Rising-edge detection against the previous clock's sample
  always_ff @(posedge clk) begin
    if (!rstN) trigPrevQ <= '0;
    else       trigPrevQ <= trigIn;
  end

  always_comb begin
    trigRise  = trigIn & ~trigPrevQ;
    trigEvent = trigRise[trigSelQ];
  end

  always_comb begin
    strb.wrLow      = wrLow;
    strb.wrHigh     = wrHigh;
    strb.leftAdj    = leftAdjQ;
    strb.fromFresh  = wrHigh;
    strb.loadShadow = autoTrig ? trigEvent : wrHigh;
  end

  always_comb begin
    ctrlRead = '0;
    ctrlRead[AUTO_BIT] = autoTrig;
    ctrlRead[LEFT_BIT] = leftAdjQ;
    ctrlRead[SEL_LSB +: SEL_W] = trigSelQ;
  end

  // R6
  level_no_refire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigEvent && !wrCtrl) |=> !trigEvent);

endmodule

// File: rtl/dacbuf_datapath.sv
module dacbuf_datapath
  import dacbuf_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int BYTE_W = 8,
  localparam int SPLIT = CODE_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  input  logic [BYTE_W-1:0] ctrlRead,
  output logic [BYTE_W-1:0] rdData,
  output logic [CODE_W-1:0] stagedCode,
  output logic [CODE_W-1:0] dacCode
);

  logic [CODE_W-1:0] holdQ, holdNext;
  logic [CODE_W-1:0] stagedQ, shadowQ;
  logic [BYTE_W-1:0] lowRead, highRead;

  // Holding value: the code as the bytes currently describe it
  always_comb begin
    holdNext = holdQ;
    if (strb.wrLow) begin
      if (strb.leftAdj) holdNext[SPLIT-1:0] = wrData[BYTE_W-1 -: SPLIT];
      else              holdNext[BYTE_W-1:0] = wrData;
    end
    if (strb.wrHigh) begin
      if (strb.leftAdj) holdNext[CODE_W-1:SPLIT] = wrData;
      else              holdNext[CODE_W-1:BYTE_W] = wrData[SPLIT-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ   <= '0;
      stagedQ <= '0;
      shadowQ <= '0;
    end else begin
      holdQ <= holdNext;
      if (strb.wrHigh) stagedQ <= holdNext;
      if (strb.loadShadow) shadowQ <= strb.fromFresh ? holdNext : stagedQ;
    end
  end

  always_comb begin
    lowRead  = '0;
    highRead = '0;
    if (strb.leftAdj) begin
      lowRead[BYTE_W-1 -: SPLIT] = holdQ[SPLIT-1:0];
      highRead = holdQ[CODE_W-1:SPLIT];
    end else begin
      lowRead = holdQ[BYTE_W-1:0];
      highRead[SPLIT-1:0] = holdQ[CODE_W-1:BYTE_W];
    end
  end

  always_comb begin
    case (rdAddr)
      REG_LOW:  rdData = lowRead;
      REG_HIGH: rdData = highRead;
      REG_CTRL: rdData = ctrlRead;
      default:  rdData = '0;
    endcase
  end

  assign stagedCode = stagedQ;
  assign dacCode    = shadowQ;

  // R3
  low_write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrLow && !strb.loadShadow) |=> $stable(shadowQ));

  // R8
  fresh_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadShadow && strb.fromFresh) |=> (shadowQ == stagedQ));

endmodule

// File: rtl/dacbuf_top.sv
module dacbuf_top
  import dacbuf_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int BYTE_W   = 8,
  parameter int NUM_TRIG = 8,
  localparam int SEL_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1,
  localparam int CTRL_W  = 2 + SEL_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [1:0]          wrAddr,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic [1:0]          rdAddr,
  output logic [BYTE_W-1:0]   rdData,
  input  logic [NUM_TRIG-1:0] trigIn,
  output logic [CODE_W-1:0]   dacCode
);

  dpStrobe_t         strb;
  logic [BYTE_W-1:0] ctrlRead;
  logic [CODE_W-1:0] stagedCode;
  logic              autoTrig, trigEvent;

  dacbuf_ctrl #(.BYTE_W(BYTE_W), .NUM_TRIG(NUM_TRIG)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .ctrlData(wrData[CTRL_W-1:0]), .trigIn(trigIn),
    .strb(strb), .ctrlRead(ctrlRead),
    .autoTrig(autoTrig), .trigEvent(trigEvent)
  );

  dacbuf_datapath #(.CODE_W(CODE_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .rdAddr(rdAddr), .ctrlRead(ctrlRead), .rdData(rdData),
    .stagedCode(stagedCode), .dacCode(dacCode)
  );

  // R4
  direct_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == REG_HIGH && !autoTrig) |=> (dacCode == stagedCode));

  // R5
  trig_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (autoTrig && !trigEvent) |=> $stable(dacCode));

  // R10
  direct_ignores_trig_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!autoTrig && !(wrEn && wrAddr == REG_HIGH)) |=> $stable(dacCode));

endmodule

// File: tb/dacbuf_top_tb.sv
module dacbuf_top_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd3;
  logic [7:0] wrData = 8'h00;
  logic [1:0] rdAddr = 2'd0;
  logic [7:0] rdData;
  logic [7:0] trigIn = 8'h00;
  logic [9:0] dacCode;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  dacbuf_top u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .trigIn(trigIn), .dacCode(dacCode)
  );

  typedef struct packed {
    logic [1:0] addr;
    logic [7:0] data;
    logic [7:0] trig;
    logic [9:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 8'hA5, 8'h00, 10'h000, 4'd3},  // R3 low alone
    '{2'd1, 8'h02, 8'h00, 10'h2A5, 4'd4},  // R4 direct load, R2 mapping
    '{2'd1, 8'hFF, 8'h00, 10'h3A5, 4'd2},  // R2 high bits 7:2 ignored
    '{2'd3, 8'h00, 8'hFF, 10'h3A5, 4'd10}, // R10 triggers ignored
    '{2'd3, 8'h00, 8'h00, 10'h3A5, 4'd10},
    '{2'd2, 8'h0D, 8'h00, 10'h3A5, 4'd5},  // auto on, sel 3
    '{2'd0, 8'h11, 8'h00, 10'h3A5, 4'd3},
    '{2'd1, 8'h01, 8'h00, 10'h3A5, 4'd5},  // R5 commit waits
    '{2'd3, 8'h00, 8'h04, 10'h3A5, 4'd6},  // R6 unselected input
    '{2'd3, 8'h00, 8'h0C, 10'h111, 4'd5},  // R5 selected edge
    '{2'd0, 8'h22, 8'h0C, 10'h111, 4'd6},  // R6 level held
    '{2'd1, 8'h00, 8'h0C, 10'h111, 4'd6},
    '{2'd3, 8'h00, 8'h00, 10'h111, 4'd6},  // R6 falling edge
    '{2'd3, 8'h00, 8'h08, 10'h022, 4'd5},  // R5 second event
    '{2'd3, 8'h00, 8'h00, 10'h022, 4'd6},
    '{2'd1, 8'h03, 8'h08, 10'h322, 4'd8},  // R8 same-cycle write and edge
    '{2'd2, 8'h02, 8'h00, 10'h322, 4'd9},  // R9 left, direct
    '{2'd1, 8'h80, 8'h00, 10'h202, 4'd7},  // R7 high only
    '{2'd0, 8'hC0, 8'h00, 10'h202, 4'd3},
    '{2'd1, 8'h7F, 8'h00, 10'h1FF, 4'd7}   // R7 full left code
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    #2;
    wrEn = 1'b0; wrAddr = 2'd3;
  endtask

  task automatic readCheck(input logic [1:0] a, input logic [7:0] exp, input string tag);
    rdAddr = a;
    #1;
    check(tag, {8'h00, rdData}, {8'h00, exp});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 code", {6'h0, dacCode}, 16'h0);
    readCheck(2'd0, 8'h00, "R1 low");
    readCheck(2'd1, 8'h00, "R1 high");
    readCheck(2'd2, 8'h00, "R1 ctrl");

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = VECS[i].addr; wrData = VECS[i].data; trigIn = VECS[i].trig;
      @(posedge clk);
      #2;
      check($sformatf("R%0d step %0d", VECS[i].req, i), {6'h0, dacCode}, {6'h0, VECS[i].exp});
    end
    @(negedge clk);
    wrEn = 1'b0; wrAddr = 2'd3; trigIn = 8'h00;

    // R7 left-adjusted readback of code 0x1FF
    readCheck(2'd1, 8'h7F, "R7 high read");
    readCheck(2'd0, 8'hC0, "R7 low read");

    // R9 switch to right: code unchanged, readback reinterpreted
    busWrite(2'd2, 8'h00);
    check("R9 code kept", {6'h0, dacCode}, 16'h01FF);
    readCheck(2'd0, 8'hFF, "R9 low read");
    readCheck(2'd1, 8'h01, "R2 high read unused zero");

    // R11 control layout and unused address
    busWrite(2'd2, 8'hFF);
    readCheck(2'd2, 8'h1F, "R11 ctrl read");
    busWrite(2'd3, 8'hAA);
    readCheck(2'd3, 8'h00, "R11 addr3 read");
    check("R11 addr3 write", {6'h0, dacCode}, 16'h01FF);

    // R1 reset again mid-run
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #2;
    rstN = 1'b1;
    #1;
    check("R1 code after reset", {6'h0, dacCode}, 16'h0);
    readCheck(2'd2, 8'h00, "R1 ctrl after reset");
    readCheck(2'd0, 8'h00, "R1 low after reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule